// File: doc/BRIEF.md
# Opposite-Edge Single-Port RAM Wrapper

This block keeps a state-machine datapath from indexing a memory array directly. All loads and stores go through one dedicated memory process. That process is clocked on the falling edge of the clock, while the rest of the logic runs on the rising edge. Because the array sits alone in its own process, a synthesis tool can map it to block RAM rather than flip-flops. Because that process works on the opposite edge, each access saves one rising-edge cycle.

A small rising-edge controller takes one command at a time. A command is a load or a store, with an address, a write word and a "last" flag. The controller registers the address, write word, write-enable and access-enable into port registers, and the memory process acts on them at the next falling edge.

- A load returns its word on the next rising edge, so it occupies two cycles.
- A store is written half a cycle after it is accepted, so it occupies one cycle.
- When the command flagged last completes, the controller raises a sticky finish flag and holds the final result in a return register. It then accepts nothing more until reset.

Top module: `oer_mem_wrap`

## Requirements
- R1: A synchronous active-high reset brings the outputs to `cmd_ready`=1, `rsp_valid`=0 and `fin`=0. The reset does not clear the array contents.
- R2: The array is read and written only on the falling clock edge, from the registered port signals. On a falling edge with the access-enable low, the array and the read register keep their values.
- R3: A load (`cmd_store`=0) is accepted at rising edge k when `cmd_valid` and `cmd_ready` are both 1. Between edges k and k+1, `cmd_ready` is 0 and `rsp_valid` is 0. After edge k+1, `rsp_valid` is 1 for exactly one cycle and `rsp_data` holds the word stored at `cmd_addr`.
- R4: A store (`cmd_store`=1) is accepted at edge k and writes `cmd_wdata` at the following falling edge. When the store is not last, `cmd_ready` stays 1, so a load accepted at edge k+1 to the same address returns the new word.
- R5: A store never raises `rsp_valid` and never changes `rsp_data`. Between loads, `rsp_data` keeps the word from the most recent load.
- R6: A command with `cmd_last`=1 sets `fin` when it completes: after edge k+1 for a load, after edge k for a store. At that point `ret` holds the loaded word or the stored word. Once set, `fin` stays set until reset.
- R7: While `fin` is 1, `cmd_ready` is 0 and commands are ignored: no array word changes and `rsp_valid` stays 0.
- R8: While `cmd_valid` is 0, no access takes place and `rsp_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; controller on rising edge, array on falling edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_store | input | 1 | 1 = store, 0 = load |
| cmd_last | input | 1 | Command is the final one |
| cmd_addr | input | ADDR_W | Word address |
| cmd_wdata | input | DATA_W | Store data |
| cmd_ready | output | 1 | Controller can take a command |
| rsp_valid | output | 1 | Load data present for one cycle |
| rsp_data | output | DATA_W | Word returned by the latest load |
| fin | output | 1 | Final command completed (sticky) |
| ret | output | DATA_W | Result of the final command |

## Verification
The assertions assume the following about the inputs:
- Commands change only between rising edges.
- No command is offered while `cmd_ready` is low, or, if one is, it is simply not counted as accepted.
- `rst` is sampled on rising edges only, including by the falling-edge checks.

The stimulus meets these assumptions:
- It drives all inputs 1 ns after each rising edge and samples at the same point.
- It starts by storing every address, so no load reads an unwritten word.
- It then mixes random loads, stores and idle cycles from a fixed seed with directed cases: store followed at once by a load of the same address, commands offered after finish, and a reset that must leave the array intact.

// File: rtl/oer_pkg.sv
package oer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_DONE = 2'd2
    } ctrl_state_e;

    typedef enum logic {
        OP_LOAD  = 1'b0,
        OP_STORE = 1'b1
    } op_e;

    function automatic logic is_store(input logic op_bit);
        return op_e'(op_bit) == OP_STORE;
    endfunction

endpackage

// File: rtl/oer_ram.sv
module oer_ram #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 256,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Only process touching the array; opposite edge to the datapath.
    always_ff @(negedge clk) begin
        if (en && we) begin
            mem[addr] <= wdata;
        end
    end

    always_ff @(negedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (en && !we) begin
            rdata <= mem[addr];
        end
    end

    // R2: idle falling edge leaves the read register alone
    a_r2_idle_hold: assert property (@(negedge clk) disable iff (rst)
        !en |=> $stable(rdata));

    // R2: a write access does not disturb the read register
    a_r2_write_no_read: assert property (@(negedge clk) disable iff (rst)
        (en && we) |=> $stable(rdata));

endmodule

// File: rtl/oer_port_regs.sv
module oer_port_regs #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_d,
    input  logic              we_d,
    input  logic [ADDR_W-1:0] addr_d,
    input  logic [DATA_W-1:0] wdata_d,
    output logic              en_q,
    output logic              we_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= 1'b0;
            we_q <= 1'b0;
        end else begin
            en_q <= en_d;
            we_q <= we_d;
        end
        addr_q  <= addr_d;
        wdata_q <= wdata_d;
    end

    // R8: a write strobe never appears without the access enable
    a_r8_we_needs_en: assert property (@(posedge clk) disable iff (rst)
        we_q |-> en_q);

endmodule

// File: rtl/oer_ctrl.sv
module oer_ctrl
    import oer_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic              cmd_store,
    input  logic              cmd_last,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              cmd_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              fin,
    output logic [DATA_W-1:0] ret,
    output logic              en_d,
    output logic              we_d,
    output logic [ADDR_W-1:0] addr_d,
    output logic [DATA_W-1:0] wdata_d,
    input  logic [DATA_W-1:0] mem_rdata
);

    ctrl_state_e state_q;
    ctrl_state_e state_n;
    logic        last_q;
    logic        accept;
    logic        acc_store;

    assign cmd_ready = (state_q == ST_IDLE);
    assign accept    = cmd_valid && cmd_ready;
    assign acc_store = accept && is_store(cmd_store);

    assign en_d    = accept;
    assign we_d    = acc_store;
    assign addr_d  = cmd_addr;
    assign wdata_d = cmd_wdata;

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (!is_store(cmd_store)) begin
                        state_n = ST_WAIT;
                    end else if (cmd_last) begin
                        state_n = ST_DONE;
                    end
                end
            end
            ST_WAIT: state_n = last_q ? ST_DONE : ST_IDLE;
            ST_DONE: state_n = ST_DONE;
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            last_q    <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
            fin       <= 1'b0;
            ret       <= '0;
        end else begin
            state_q   <= state_n;
            rsp_valid <= (state_q == ST_WAIT);
            if (accept) begin
                last_q <= cmd_last;
            end
            if (state_q == ST_WAIT) begin
                rsp_data <= mem_rdata;
                if (last_q) begin
                    fin <= 1'b1;
                    ret <= mem_rdata;
                end
            end
            if (acc_store && cmd_last) begin
                fin <= 1'b1;
                ret <= cmd_wdata;
            end
        end
    end

    // R3: a load blocks the next cycle and responds one cycle later
    a_r3_load_latency: assert property (@(posedge clk) disable iff (rst)
        (accept && !cmd_store) |=> (!cmd_ready && !rsp_valid) ##1 rsp_valid);

    // R4: a non-final store leaves the controller ready
    a_r4_store_ready: assert property (@(posedge clk) disable iff (rst)
        (acc_store && !cmd_last) |=> cmd_ready);

    // R5: stores produce no response and keep the response word
    a_r5_store_no_resp: assert property (@(posedge clk) disable iff (rst)
        acc_store |=> (!rsp_valid && $stable(rsp_data)));

    // R6: finish is sticky
    a_r6_fin_sticky: assert property (@(posedge clk) disable iff (rst)
        fin |=> fin);

    // R7: nothing is accepted after finish
    a_r7_closed_after_fin: assert property (@(posedge clk) disable iff (rst)
        fin |-> !cmd_ready);

endmodule

// File: rtl/oer_mem_wrap.sv
module oer_mem_wrap #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 256,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic              cmd_store,
    input  logic              cmd_last,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              cmd_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              fin,
    output logic [DATA_W-1:0] ret
);

    logic              en_d;
    logic              we_d;
    logic [ADDR_W-1:0] addr_d;
    logic [DATA_W-1:0] wdata_d;
    logic              en_q;
    logic              we_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] mem_rdata;

    oer_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_store (cmd_store),
        .cmd_last  (cmd_last),
        .cmd_addr  (cmd_addr),
        .cmd_wdata (cmd_wdata),
        .cmd_ready (cmd_ready),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .fin       (fin),
        .ret       (ret),
        .en_d      (en_d),
        .we_d      (we_d),
        .addr_d    (addr_d),
        .wdata_d   (wdata_d),
        .mem_rdata (mem_rdata)
    );

    oer_port_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .en_d    (en_d),
        .we_d    (we_d),
        .addr_d  (addr_d),
        .wdata_d (wdata_d),
        .en_q    (en_q),
        .we_q    (we_q),
        .addr_q  (addr_q),
        .wdata_q (wdata_q)
    );

    oer_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
        .clk   (clk),
        .rst   (rst),
        .en    (en_q),
        .we    (we_q),
        .addr  (addr_q),
        .wdata (wdata_q),
        .rdata (mem_rdata)
    );

endmodule

// File: tb/oer_mem_wrap_tb.sv
`timescale 1ns/1ps
module oer_mem_wrap_tb;

    localparam int DATA_W = 32;
    localparam int DEPTH  = 256;
    localparam int ADDR_W = $clog2(DEPTH);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cmd_valid = 1'b0;
    logic              cmd_store = 1'b0;
    logic              cmd_last = 1'b0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [DATA_W-1:0] cmd_wdata = '0;
    logic              cmd_ready;
    logic              rsp_valid;
    logic [DATA_W-1:0] rsp_data;
    logic              fin;
    logic [DATA_W-1:0] ret;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [DATA_W-1:0] model [DEPTH];
    logic [DATA_W-1:0] last_load = '0;

    always #2 clk = ~clk;

    oer_mem_wrap #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_store(cmd_store),
        .cmd_last(cmd_last), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .cmd_ready(cmd_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .fin(fin), .ret(ret)
    );

    function automatic logic [DATA_W-1:0] pattern(input int i);
        return (32'h9E37_79B9 * (i + 1)) ^ 32'h5A5A_0000;
    endfunction

    task automatic check(input string req, input logic [DATA_W-1:0] act,
                         input logic [DATA_W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // All tasks start and end 1 ns after a rising edge.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_store(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                            input logic last);
        cmd_valid = 1'b1; cmd_store = 1'b1; cmd_last = last;
        cmd_addr = a; cmd_wdata = d;
        step();
        cmd_valid = 1'b0; cmd_last = 1'b0;
        model[a] = d;
        check("R5 store rsp_valid", {31'd0, rsp_valid}, 32'd0);
        check("R5 rsp_data held", rsp_data, last_load);
        if (!last) check("R4 ready after store", {31'd0, cmd_ready}, 32'd1);
        else begin
            check("R6 fin after last store", {31'd0, fin}, 32'd1);
            check("R6 ret store", ret, d);
        end
    endtask

    task automatic do_load(input logic [ADDR_W-1:0] a, input logic last);
        cmd_valid = 1'b1; cmd_store = 1'b0; cmd_last = last; cmd_addr = a;
        step();
        cmd_valid = 1'b0; cmd_last = 1'b0;
        check("R3 ready low in load", {31'd0, cmd_ready}, 32'd0);
        check("R3 no early rsp", {31'd0, rsp_valid}, 32'd0);
        step();
        check("R3 rsp_valid", {31'd0, rsp_valid}, 32'd1);
        check("R3 R2 rsp_data", rsp_data, model[a]);
        last_load = model[a];
        if (last) begin
            check("R6 fin after last load", {31'd0, fin}, 32'd1);
            check("R6 ret load", ret, model[a]);
        end
    endtask

    task automatic do_idle();
        cmd_valid = 1'b0;
        step();
        check("R8 idle rsp_valid", {31'd0, rsp_valid}, 32'd0);
        check("R5 rsp_data held idle", rsp_data, last_load);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step();
        step();
        rst = 1'b0;
        check("R1 ready", {31'd0, cmd_ready}, 32'd1);
        check("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
        check("R1 fin", {31'd0, fin}, 32'd0);
        last_load = '0;
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd20240);
        step();
        do_reset();
        for (int i = 0; i < DEPTH; i++) do_store(ADDR_W'(i), pattern(i), 1'b0);
        // R2 readback of the written pattern, directed corners first
        do_load('0, 1'b0);
        do_load(ADDR_W'(DEPTH - 1), 1'b0);
        // R4 back-to-back store then load, same address
        do_store(8'h3C, 32'hDEAD_BEEF, 1'b0);
        do_load(8'h3C, 1'b0);
        do_store(ADDR_W'(DEPTH - 1), 32'hFFFF_FFFF, 1'b0);
        do_load(ADDR_W'(DEPTH - 1), 1'b0);
        do_idle();
        for (int i = 0; i < 3000; i++) begin
            int kind;
            logic [ADDR_W-1:0] a;
            kind = int'($urandom_range(0, 9));
            a = ADDR_W'($urandom_range(0, DEPTH - 1));
            if (kind < 4) do_store(a, DATA_W'($urandom), 1'b0);
            else if (kind < 9) do_load(a, 1'b0);
            else do_idle();
        end
        // R6 last load, then R7 commands ignored while finished
        do_load(8'h10, 1'b1);
        for (int i = 0; i < 4; i++) begin
            cmd_valid = 1'b1; cmd_store = 1'b1; cmd_addr = 8'h10;
            cmd_wdata = 32'h1234_5678;
            step();
            check("R7 ready low after fin", {31'd0, cmd_ready}, 32'd0);
            check("R7 rsp_valid after fin", {31'd0, rsp_valid}, 32'd0);
            check("R6 fin sticky", {31'd0, fin}, 32'd1);
        end
        cmd_valid = 1'b0;
        do_reset();
        do_load(8'h10, 1'b0);   // R7 word unchanged, R1 array survives reset
        // R6 last store
        do_store(8'h20, 32'hCAFE_F00D, 1'b1);
        step();
        check("R6 fin sticky store", {31'd0, fin}, 32'd1);
        do_reset();
        do_load(8'h20, 1'b0);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule